// File: doc/BRIEF.md
# CKE Power State Controller

This block follows the low-power states that a synchronous DRAM enters and leaves under control of its clock-enable input. On every rising clock edge it compares the clock-enable level sampled on this edge with the level from the previous edge. It combines that edge with an already decoded command code and with a flag that says whether every bank is precharged. From these it keeps the device in one of five states: normal operation, self-refresh, the recovery wait after self-refresh, power-down, or clock suspend.

Three outputs go to the rest of the memory model. The first is the present state. The second flag says that command inputs are currently ignored. The third is a one-cycle pulse that marks a transition or command that is not allowed. When the device leaves self-refresh, it waits for a row-cycle recovery time before it returns to normal. That time is loaded from an input when the exit starts, so it can be changed between exits.

Top module: `cke_power_ctl`

## Requirements
- R1: During and after reset the state is NORMAL (code 0), inputsIgnored is 0 and illegalTrans is 0. The clock-enable history is taken as high, so the first cycle with cke low counts as a falling edge.
- R2: In NORMAL, a cke falling edge (high on the previous edge, low now) with allBanksIdle=1 and command REFRESH (code 6) moves the state to SELFREF (code 1) on the next cycle.
- R3: In NORMAL, a cke falling edge with allBanksIdle=1 and command NOP (code 0) or DESELECT (code 1) moves the state to PWRDN (code 3).
- R4: In NORMAL, a cke falling edge with allBanksIdle=1 and any other command (codes 2 to 5 and 7) leaves the state in NORMAL. illegalTrans is then high for exactly the one cycle after that edge.
- R5: In NORMAL, a cke falling edge with allBanksIdle=0 moves the state to SUSPEND (code 4) whatever the command. In SUSPEND, a cke rising edge returns the state to NORMAL.
- R6: In PWRDN, a cke rising edge (low on the previous edge, high now) returns the state to NORMAL whatever the command.
- R7: In SELFREF, a cke rising edge with NOP or DESELECT moves the state to SREXIT (code 2) and captures trcCycles. The state stays in SREXIT for max(trcCycles,1) cycles and then becomes NORMAL.
- R8: In SELFREF, a cke rising edge with any command other than NOP or DESELECT raises illegalTrans for one cycle, and the state stays SELFREF.
- R9: In SREXIT, every command other than NOP or DESELECT raises illegalTrans for one cycle. Neither such commands nor cke changes shorten or extend the wait.
- R10: inputsIgnored is high exactly while the state is SELFREF, PWRDN or SUSPEND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable level sampled on this edge |
| cmdCode | input | 3 | Decoded command: 0 NOP, 1 DESELECT, 2 ACTIVATE, 3 READ, 4 WRITE, 5 PRECHARGE, 6 REFRESH, 7 MODE |
| allBanksIdle | input | 1 | High when every bank is precharged |
| trcCycles | input | TRC_W | Recovery wait length, captured when self-refresh exit starts |
| pwrState | output | 3 | Current state: 0 NORMAL, 1 SELFREF, 2 SREXIT, 3 PWRDN, 4 SUSPEND |
| inputsIgnored | output | 1 | Command inputs are currently ignored |
| illegalTrans | output | 1 | One-cycle pulse marking a disallowed transition or command |

## Verification
The assertions assume that cke, cmdCode, allBanksIdle and trcCycles are stable across each rising edge. They also assume that the edge detection sees only the levels sampled on successive edges. No assumption about command legality is made outside the rules above. The stimulus changes every input only at the falling clock edge. It holds cke at its level most of the time, so that long stays in self-refresh, power-down and suspend occur. Most commands are NOP, and allBanksIdle is mostly high, so that all three entry paths from NORMAL are reached. trcCycles is drawn from a small range that includes 0 and 1.

// File: rtl/cke_pkg.sv
package cke_pkg;

  typedef enum logic [2:0] {
    PS_NORMAL  = 3'd0,
    PS_SELFREF = 3'd1,
    PS_SREXIT  = 3'd2,
    PS_PWRDN   = 3'd3,
    PS_SUSPEND = 3'd4
  } pwrState_e;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_DESEL = 3'd1,
    CMD_ACT   = 3'd2,
    CMD_READ  = 3'd3,
    CMD_WRITE = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_REF   = 3'd6,
    CMD_MODE  = 3'd7
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWait;
    logic stepWait;
  } waitStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic ckeFall;
    logic ckeRise;
    logic cmdIdleLike;
    logic cmdRefresh;
    logic waitDone;
  } dpStatus_t;

endpackage

// File: rtl/cke_dp.sv
module cke_dp
  import cke_pkg::*;
#(
  parameter int TRC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  logic [2:0]       cmdCode,
  input  logic [TRC_W-1:0] trcCycles,
  input  waitStrobe_t      strobe,
  output dpStatus_t        status
);

  localparam logic [TRC_W-1:0] ONE = TRC_W'(1);

  logic             ckePrev;
  logic [TRC_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) ckePrev <= 1'b1;
    else       ckePrev <= cke;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          waitCnt <= '0;
    else if (strobe.loadWait)           waitCnt <= trcCycles;
    else if (strobe.stepWait && waitCnt > ONE) waitCnt <= waitCnt - ONE;
  end

  always_comb begin
    status.ckeFall     = ckePrev & ~cke;
    status.ckeRise     = ~ckePrev & cke;
    status.cmdIdleLike = (cmdCode == CMD_NOP) || (cmdCode == CMD_DESEL);
    status.cmdRefresh  = (cmdCode == CMD_REF);
    status.waitDone    = (waitCnt <= ONE);
  end

  // R7: the recovery counter takes the programmed length on load
  a_r7_wait_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWait |=> waitCnt == $past(trcCycles));

  // R9: during the wait the counter only steps down by one
  a_r9_wait_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepWait && !strobe.loadWait && waitCnt > ONE) |=> waitCnt == $past(waitCnt) - ONE);

endmodule

// File: rtl/cke_ctl.sv
module cke_ctl
  import cke_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        allBanksIdle,
  input  dpStatus_t   status,
  output waitStrobe_t strobe,
  output pwrState_e   stateQ,
  output logic        illegalQ
);

  pwrState_e stateD;
  logic      illegalD;

  always_comb begin
    stateD          = stateQ;
    illegalD        = 1'b0;
    strobe.loadWait = 1'b0;
    strobe.stepWait = 1'b0;
    unique case (stateQ)
      PS_NORMAL: begin
        if (status.ckeFall) begin
          if (!allBanksIdle)            stateD = PS_SUSPEND;
          else if (status.cmdRefresh)   stateD = PS_SELFREF;
          else if (status.cmdIdleLike)  stateD = PS_PWRDN;
          else                          illegalD = 1'b1;
        end
      end
      PS_SELFREF: begin
        if (status.ckeRise) begin
          if (status.cmdIdleLike) begin
            stateD          = PS_SREXIT;
            strobe.loadWait = 1'b1;
          end else begin
            illegalD = 1'b1;
          end
        end
      end
      PS_SREXIT: begin
        strobe.stepWait = 1'b1;
        if (!status.cmdIdleLike) illegalD = 1'b1;
        if (status.waitDone)     stateD = PS_NORMAL;
      end
      PS_PWRDN: begin
        if (status.ckeRise) stateD = PS_NORMAL;
      end
      PS_SUSPEND: begin
        if (status.ckeRise) stateD = PS_NORMAL;
      end
      default: stateD = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= PS_NORMAL;
      illegalQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      illegalQ <= illegalD;
    end
  end

  // R2: refresh with clock-enable falling while idle enters self-refresh
  a_r2_selfref_entry: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PS_NORMAL && status.ckeFall && allBanksIdle && status.cmdRefresh)
      |=> stateQ == PS_SELFREF);

  // R3: NOP/deselect with falling edge while idle enters power-down
  a_r3_pwrdn_entry: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PS_NORMAL && status.ckeFall && allBanksIdle && status.cmdIdleLike)
      |=> stateQ == PS_PWRDN);

  // R5: falling edge with open banks suspends the clock
  a_r5_suspend_entry: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PS_NORMAL && status.ckeFall && !allBanksIdle) |=> stateQ == PS_SUSPEND);

  // R6: rising edge leaves power-down
  a_r6_pwrdn_exit: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PS_PWRDN && status.ckeRise) |=> stateQ == PS_NORMAL);

  // R7: self-refresh is left only through the recovery wait
  a_r7_no_skip: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == PS_SELFREF |=> (stateQ == PS_SELFREF || stateQ == PS_SREXIT));

  // R8: a disallowed exit command keeps self-refresh
  a_r8_bad_exit: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PS_SELFREF && status.ckeRise && !status.cmdIdleLike)
      |=> (stateQ == PS_SELFREF && illegalQ));

  // R4: illegal pulse only follows states that can flag it
  a_r4_illegal_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(illegalQ) |-> ($past(stateQ) == PS_NORMAL || $past(stateQ) == PS_SELFREF
                         || $past(stateQ) == PS_SREXIT));

endmodule

// File: rtl/cke_power_ctl.sv
module cke_power_ctl
  import cke_pkg::*;
#(
  parameter int TRC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  logic [2:0]       cmdCode,
  input  logic             allBanksIdle,
  input  logic [TRC_W-1:0] trcCycles,
  output logic [2:0]       pwrState,
  output logic             inputsIgnored,
  output logic             illegalTrans
);

  waitStrobe_t strobe;
  dpStatus_t   status;
  pwrState_e   stateQ;

  cke_dp #(.TRC_W(TRC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cke       (cke),
    .cmdCode   (cmdCode),
    .trcCycles (trcCycles),
    .strobe    (strobe),
    .status    (status)
  );

  cke_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .allBanksIdle (allBanksIdle),
    .status       (status),
    .strobe       (strobe),
    .stateQ       (stateQ),
    .illegalQ     (illegalTrans)
  );

  assign pwrState      = stateQ;
  assign inputsIgnored = (stateQ == PS_SELFREF) || (stateQ == PS_PWRDN)
                      || (stateQ == PS_SUSPEND);

  // R10: no ignoring of inputs outside the three low-power states
  a_r10_ignore_states: assert property (@(posedge clk) disable iff (!rstN)
    inputsIgnored |-> (pwrState != 3'd0 && pwrState != 3'd2));

  // R1: the state code never leaves the defined set
  a_r1_state_range: assert property (@(posedge clk) disable iff (!rstN)
    pwrState <= 3'd4);

endmodule

// File: tb/cke_power_ctl_test.sv
module cke_power_ctl_test;

  localparam int CLK_PERIOD = 10;
  localparam int TRC_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cke = 1'b1;
  logic [2:0]       cmdCode = 3'd0;
  logic             allBanksIdle = 1'b1;
  logic [TRC_W-1:0] trcCycles = '0;
  logic [2:0]       pwrState;
  logic             inputsIgnored;
  logic             illegalTrans;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model
  logic       mPrev = 1'b1;
  logic [2:0] mState = 3'd0;
  int         mCnt = 0;
  logic       mIll = 1'b0;
  string      mWhy = "R1";
  string      mIllWhy = "R4";

  cke_power_ctl #(.TRC_W(TRC_W)) uut (
    .clk(clk), .rstN(rstN), .cke(cke), .cmdCode(cmdCode),
    .allBanksIdle(allBanksIdle), .trcCycles(trcCycles),
    .pwrState(pwrState), .inputsIgnored(inputsIgnored), .illegalTrans(illegalTrans)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic expIgnored(logic [2:0] s);
    return (s == 3'd1) || (s == 3'd3) || (s == 3'd4);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    check(mWhy, pwrState, mState);
    check("R10", inputsIgnored, expIgnored(mState));
    check(mIll ? mIllWhy : "R4", illegalTrans, mIll);
  endtask

  task automatic modelStep(logic c, logic [2:0] cmd, logic idle, int trc);
    logic fall = mPrev && !c;
    logic rise = !mPrev && c;
    logic idleLike = (cmd == 3'd0) || (cmd == 3'd1);
    mIll = 1'b0;
    case (mState)
      3'd0: if (fall) begin
        if (!idle)             begin mState = 3'd4; mWhy = "R5"; end
        else if (cmd == 3'd6)  begin mState = 3'd1; mWhy = "R2"; end
        else if (idleLike)     begin mState = 3'd3; mWhy = "R3"; end
        else                   begin mIll = 1'b1; mIllWhy = "R4"; end
      end
      3'd1: if (rise) begin
        if (idleLike) begin mState = 3'd2; mCnt = trc; mWhy = "R7"; end
        else          begin mIll = 1'b1; mIllWhy = "R8"; end
      end
      3'd2: begin
        if (!idleLike) begin mIll = 1'b1; mIllWhy = "R9"; end
        if (mCnt <= 1) begin mState = 3'd0; mWhy = "R7"; end
        else mCnt--;
      end
      3'd3: if (rise) begin mState = 3'd0; mWhy = "R6"; end
      3'd4: if (rise) begin mState = 3'd0; mWhy = "R5"; end
      default: ;
    endcase
    mPrev = c;
  endtask

  // check the outputs of the previous edge, then drive the next inputs
  task automatic step(logic c, logic [2:0] cmd, logic idle, int trc);
    @(negedge clk);
    checkAll();
    cke = c; cmdCode = cmd; allBanksIdle = idle; trcCycles = TRC_W'(trc);
    modelStep(c, cmd, idle, trc);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int c;
    int cmd;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", pwrState, 0);
    check("R1", inputsIgnored, 0);
    check("R1", illegalTrans, 0);
    rstN = 1'b1;
    // R1: first low cke after reset is a falling edge -> power-down
    step(1'b0, 3'd0, 1'b1, 0);
    step(1'b0, 3'd5, 1'b1, 0);
    step(1'b1, 3'd4, 1'b0, 0);   // R6 exit with any command
    step(1'b1, 3'd0, 1'b1, 0);
    // R4 illegal entry attempt
    step(1'b0, 3'd2, 1'b1, 0);
    step(1'b1, 3'd0, 1'b1, 0);
    // R5 suspend and exit
    step(1'b0, 3'd3, 1'b0, 0);
    step(1'b0, 3'd0, 1'b0, 0);
    step(1'b1, 3'd0, 1'b0, 0);
    step(1'b1, 3'd0, 1'b1, 0);
    // R2 self-refresh, R8 bad exit, R7 exit with trc=0
    step(1'b0, 3'd6, 1'b1, 3);
    step(1'b1, 3'd2, 1'b1, 3);
    step(1'b0, 3'd0, 1'b1, 3);
    step(1'b1, 3'd1, 1'b1, 0);
    step(1'b1, 3'd0, 1'b1, 0);
    // R7 trc=1 and R9 commands and cke drops during a trc=5 wait
    step(1'b0, 3'd6, 1'b1, 1);
    step(1'b1, 3'd0, 1'b1, 1);
    step(1'b1, 3'd0, 1'b1, 1);
    step(1'b0, 3'd6, 1'b1, 5);
    step(1'b1, 3'd0, 1'b1, 5);
    step(1'b0, 3'd3, 1'b1, 9);
    step(1'b1, 3'd7, 1'b1, 9);
    step(1'b1, 3'd0, 1'b1, 9);
    step(1'b1, 3'd0, 1'b1, 9);
    step(1'b1, 3'd0, 1'b1, 9);
    step(1'b1, 3'd0, 1'b1, 9);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      c = (($urandom % 4) == 0) ? !cke : cke;
      cmd = (($urandom % 3) == 0) ? int'($urandom % 8) : int'($urandom % 2);
      if (($urandom % 6) == 0) cmd = 6;
      step(c[0], cmd[2:0], ($urandom % 10) < 7, int'($urandom % 6));
    end
    @(negedge clk);
    checkAll();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule